// File: doc/BRIEF.md
# Type-II Digital Angle Tracking Loop

This block follows a rotating shaft angle, given as a stream of signed sine and cosine samples. It keeps its own estimate φ in a wrapping up/down counter. On every sample strobe it forms the cross-product error sinθ·cosφ − cosθ·sinφ, which is proportional to sin(θ−φ). The sine and cosine of φ are read from a quarter-wave table. The error drives a proportional-plus-integral filter. The filter output is a signed rate word that feeds a phase accumulator. Each accumulator carry moves the counter one LSB, up or down according to the sign of the rate. Because the filter contains an integrator and the counter adds a second integration, the loop is type II: once it has acquired, a constant rotation is followed with no average lag.

The outputs are the angle word, one-cycle step pulses for each direction, and a velocity word. The velocity word is the integrator state, so it scales with the rotation rate. Both loop gains are power-of-two shifts. They are tuned for a sample strobe every four clocks at near full-scale input amplitude. The largest trackable rate is one LSB per clock, set by the accumulator width. With fewer angle bits, each step covers a larger angle, so a given step rate corresponds to more revolutions per second.

Top module: `angle_track_loop`

## Requirements
- R1: After reset the angle is 0, the velocity word is 0, and both step pulses are low.
- R2: On each sample strobe the error is computed as (sin_in·cosφ − cos_in·sinφ) arithmetically shifted right by SMP_W+TRIG_W−ERR_W. It holds its value between strobes.
- R3: For a static input angle, the angle settles to within 2 LSB of the input within 3000 samples, and then stays there for at least 50 consecutive samples.
- R4: Each up pulse increments the angle by exactly one in the same cycle, and each down pulse decrements it by exactly one. Without a pulse the angle does not change.
- R5: The up and down pulses are never high together, so at most one step occurs per clock.
- R6: The angle wraps modulo 2^ANG_W in both directions: 2^ANG_W−1 steps up to 0, and 0 steps down to 2^ANG_W−1.
- R7: Under a constant rotation of up to 3 LSB per sample, the tracking lag after acquisition stays within 6 LSB.
- R8: The velocity word equals the integrator, which changes only on sample strobes. In steady rotation it averages v·2^ACC_W/S, where v is the rate in LSB per sample and S is the number of clocks per sample, and its sign matches the direction of rotation.
- R9: The integrator and the rate word saturate at ±(2^ACC_W−1) and never wrap. An input rotating faster than the limit drives the velocity word to exactly +(2^ACC_W−1).
- R10: sinφ and cosφ come from a quarter-wave table of amplitude 2^(TRIG_W−1)−1. The table is addressed by the top bits of the counter, and the two MSBs select the quadrant, so the loop locks in all four quadrants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Strobe: a new sine/cosine pair is valid |
| sin_in | input | SMP_W | Signed sine sample of the input angle |
| cos_in | input | SMP_W | Signed cosine sample of the input angle |
| angle_o | output | ANG_W | Tracked angle, full scale is one revolution |
| up_o | output | 1 | One-cycle pulse: the angle stepped up |
| dn_o | output | 1 | One-cycle pulse: the angle stepped down |
| vel_o | output | ACC_W+1 | Signed velocity word (integrator state) |

## Verification
The assertions take for granted that the strobes are spaced at least a few clocks apart. They also assume that sin_in and cos_in describe a point near the unit circle at constant amplitude, because the error scale, and with it the loop gain, depends on that amplitude. The stimulus drives a sample every four clocks at amplitude 2000 of 2047. In the tracking tests the rate stays within ±3 LSB per sample. A faster rate appears only in the deliberate overspeed run, whose purpose is to drive the integrator into saturation.

// File: rtl/atl_pkg.sv
package atl_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DN   = 2'b10
  } step_e;
endpackage

// File: rtl/atl_trig_rom.sv
module atl_trig_rom #(
  parameter int ANG_W  = 12,
  parameter int TRIG_W = 12,
  parameter int LUT_AW = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ANG_W-1:0]         ang_i,
  output logic signed [TRIG_W-1:0] sin_o,
  output logic signed [TRIG_W-1:0] cos_o
);
  localparam int  DEPTH   = 1 << LUT_AW;
  localparam real HALF_PI = 1.5707963267948966;
  localparam logic [TRIG_W-2:0] AMP = '1;

  logic [TRIG_W-2:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      rom[i] = (TRIG_W-1)'($rtoi(real'(AMP) * $sin(real'(i) * HALF_PI / real'(DEPTH)) + 0.5));
  end

  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx, mir;
  logic              idx_zero;

  assign quad     = ang_i[ANG_W-1 -: 2];
  assign idx      = ang_i[ANG_W-3 -: LUT_AW];
  assign mir      = LUT_AW'(~idx + 1'b1);
  assign idx_zero = (idx == '0);

  logic [TRIG_W-2:0] rd_s, rd_c;
  logic              s_full, c_full, s_neg, c_neg;

  always_ff @(posedge clk) begin
    rd_s <= rom[quad[0] ? mir : idx];
    rd_c <= rom[quad[0] ? idx : mir];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_full <= 1'b0;
      c_full <= 1'b1;
      s_neg  <= 1'b0;
      c_neg  <= 1'b0;
    end else begin
      s_full <= quad[0] & idx_zero;
      c_full <= ~quad[0] & idx_zero;
      s_neg  <= quad[1];
      c_neg  <= quad[1] ^ quad[0];
    end
  end

  logic [TRIG_W-2:0] s_mag, c_mag;
  assign s_mag = s_full ? AMP : rd_s;
  assign c_mag = c_full ? AMP : rd_c;
  assign sin_o = s_neg ? -$signed({1'b0, s_mag}) : $signed({1'b0, s_mag});
  assign cos_o = c_neg ? -$signed({1'b0, c_mag}) : $signed({1'b0, c_mag});

  AST_TRIG_AXIS: assert property (@(posedge clk) disable iff (rst)
    s_full |-> (cos_o == '0)); // R10
endmodule

// File: rtl/atl_phase_err.sv
module atl_phase_err #(
  parameter int SMP_W  = 12,
  parameter int TRIG_W = 12,
  parameter int ERR_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vld_i,
  input  logic signed [SMP_W-1:0]  sin_i,
  input  logic signed [SMP_W-1:0]  cos_i,
  input  logic signed [TRIG_W-1:0] sin_phi_i,
  input  logic signed [TRIG_W-1:0] cos_phi_i,
  output logic signed [ERR_W-1:0]  err_o,
  output logic                     vld_o
);
  localparam int PROD_W = SMP_W + TRIG_W;
  localparam int ERR_SH = PROD_W - ERR_W;

  logic signed [PROD_W-1:0] p_a, p_b;
  logic signed [PROD_W:0]   diff;

  assign p_a  = sin_i * cos_phi_i;
  assign p_b  = cos_i * sin_phi_i;
  assign diff = p_a - p_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) err_o <= ERR_W'(diff >>> ERR_SH);
    end
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> $stable(err_o)); // R2
endmodule

// File: rtl/atl_pi_filter.sv
module atl_pi_filter #(
  parameter int ERR_W = 12,
  parameter int ACC_W = 16,
  parameter int KP_SH = 11,
  parameter int KI_SH = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vld_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic signed [ACC_W:0]   rate_o,
  output logic signed [ACC_W:0]   integ_o
);
  localparam int INT_W = ACC_W + 1;
  localparam int W     = ACC_W + ERR_W + KP_SH + 2;
  localparam logic signed [W-1:0]     LIM_W = W'((64'd1 << ACC_W) - 64'd1);
  localparam logic signed [INT_W-1:0] LIM_I = INT_W'((64'd1 << ACC_W) - 64'd1);

  function automatic logic signed [INT_W-1:0] clip(input logic signed [W-1:0] x);
    if (x > LIM_W)       return LIM_I;
    else if (x < -LIM_W) return -LIM_I;
    else                 return x[INT_W-1:0];
  endfunction

  logic signed [W-1:0]     e_w, i_sum, r_sum;
  logic signed [INT_W-1:0] i_nxt;

  assign e_w   = {{(W-ERR_W){err_i[ERR_W-1]}}, err_i};
  assign i_sum = {{(W-INT_W){integ_o[INT_W-1]}}, integ_o} + (e_w <<< KI_SH);
  assign i_nxt = clip(i_sum);
  assign r_sum = {{(W-INT_W){i_nxt[INT_W-1]}}, i_nxt} + (e_w <<< KP_SH);

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_o <= '0;
      rate_o  <= '0;
    end else if (vld_i) begin
      integ_o <= i_nxt;
      rate_o  <= clip(r_sum);
    end
  end

  AST_INT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (integ_o <= LIM_I) && (integ_o >= -LIM_I)); // R9
  AST_RATE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (rate_o <= LIM_I) && (rate_o >= -LIM_I)); // R9
  AST_INT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> $stable(integ_o)); // R8
endmodule

// File: rtl/atl_nco_count.sv
module atl_nco_count
  import atl_pkg::*;
#(
  parameter int ANG_W = 12,
  parameter int ACC_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic signed [ACC_W:0] rate_i,
  output logic [ANG_W-1:0]      cnt_o,
  output logic                  up_o,
  output logic                  dn_o
);
  logic [ACC_W-1:0] acc_q, mag;
  logic [ACC_W:0]   sum;
  step_e            st;

  assign mag = rate_i[ACC_W] ? ACC_W'(-rate_i) : ACC_W'(rate_i);
  assign sum = {1'b0, acc_q} + {1'b0, mag};

  always_comb begin
    st = STEP_NONE;
    if (sum[ACC_W]) st = rate_i[ACC_W] ? STEP_DN : STEP_UP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      cnt_o <= '0;
      up_o  <= 1'b0;
      dn_o  <= 1'b0;
    end else begin
      acc_q <= sum[ACC_W-1:0];
      up_o  <= (st == STEP_UP);
      dn_o  <= (st == STEP_DN);
      case (st)
        STEP_UP: cnt_o <= cnt_o + 1'b1;
        STEP_DN: cnt_o <= cnt_o - 1'b1;
        default: cnt_o <= cnt_o;
      endcase
    end
  end

  AST_ONE_DIR: assert property (@(posedge clk) disable iff (rst)
    !(up_o && dn_o)); // R5
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    up_o |-> (cnt_o == ANG_W'($past(cnt_o) + 1'b1))); // R4
  AST_STEP_DN: assert property (@(posedge clk) disable iff (rst)
    dn_o |-> (cnt_o == ANG_W'($past(cnt_o) - 1'b1))); // R4
  AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(up_o || dn_o) |-> $stable(cnt_o)); // R4
endmodule

// File: rtl/angle_track_loop.sv
module angle_track_loop #(
  parameter int ANG_W  = 12,
  parameter int SMP_W  = 12,
  parameter int TRIG_W = 12,
  parameter int LUT_AW = 10,
  parameter int ERR_W  = 12,
  parameter int ACC_W  = 16,
  parameter int KP_SH  = 11,
  parameter int KI_SH  = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_vld,
  input  logic signed [SMP_W-1:0] sin_in,
  input  logic signed [SMP_W-1:0] cos_in,
  output logic [ANG_W-1:0]        angle_o,
  output logic                    up_o,
  output logic                    dn_o,
  output logic signed [ACC_W:0]   vel_o
);
  logic signed [TRIG_W-1:0] sin_phi, cos_phi;
  logic signed [ERR_W-1:0]  err;
  logic                     err_vld;
  logic signed [ACC_W:0]    rate;

  atl_trig_rom #(.ANG_W(ANG_W), .TRIG_W(TRIG_W), .LUT_AW(LUT_AW)) u_rom (
    .clk(clk), .rst(rst), .ang_i(angle_o), .sin_o(sin_phi), .cos_o(cos_phi));

  atl_phase_err #(.SMP_W(SMP_W), .TRIG_W(TRIG_W), .ERR_W(ERR_W)) u_err (
    .clk(clk), .rst(rst), .vld_i(smp_vld), .sin_i(sin_in), .cos_i(cos_in),
    .sin_phi_i(sin_phi), .cos_phi_i(cos_phi), .err_o(err), .vld_o(err_vld));

  atl_pi_filter #(.ERR_W(ERR_W), .ACC_W(ACC_W), .KP_SH(KP_SH), .KI_SH(KI_SH)) u_pi (
    .clk(clk), .rst(rst), .vld_i(err_vld), .err_i(err), .rate_o(rate), .integ_o(vel_o));

  atl_nco_count #(.ANG_W(ANG_W), .ACC_W(ACC_W)) u_nco (
    .clk(clk), .rst(rst), .rate_i(rate), .cnt_o(angle_o), .up_o(up_o), .dn_o(dn_o));
endmodule

// File: tb/sim_angle_track_loop.sv
module sim_angle_track_loop;
  localparam int  ANG_W = 12;
  localparam int  ACC_W = 16;
  localparam int  SPS   = 4;
  localparam real AMPL  = 2000.0;
  localparam real FULL  = 4096.0;
  localparam real TWO_PI = 6.283185307179586;
  localparam int  VMAX  = (1 << ACC_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic signed [11:0] sin_in = '0, cos_in = '0;
  logic [ANG_W-1:0] angle;
  logic up, dn;
  logic signed [ACC_W:0] vel;

  int checks = 0, fails = 0;
  int step_err = 0, excl_err = 0, wrap_up = 0, wrap_dn = 0;
  real theta = 0.0, vrate = 0.0;
  logic [ANG_W-1:0] prev_ang = '0;

  always #2.5 clk = ~clk;

  angle_track_loop u0 (.clk(clk), .rst(rst), .smp_vld(smp_vld), .sin_in(sin_in),
    .cos_in(cos_in), .angle_o(angle), .up_o(up), .dn_o(dn), .vel_o(vel));

  function automatic real wrapd(input real d);
    real r = d;
    while (r >= FULL / 2.0) r -= FULL;
    while (r < -FULL / 2.0) r += FULL;
    return r;
  endfunction

  function automatic real absr(input real d);
    return (d < 0.0) ? -d : d;
  endfunction

  function automatic logic signed [11:0] quant(input real x);
    return 12'($rtoi(x >= 0.0 ? x + 0.5 : x - 0.5));
  endfunction

  task automatic check(input bit ok, input string req, input string what, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (up && dn) excl_err++;
      if (angle !== ANG_W'(prev_ang + (up ? 1 : 0) - (dn ? 1 : 0))) step_err++;
      if (up && prev_ang == '1 && angle == '0) wrap_up++;
      if (dn && prev_ang == '0 && angle == '1) wrap_dn++;
    end
    prev_ang = angle;
  end

  task automatic one_sample();
    @(negedge clk);
    theta = theta + vrate;
    while (theta >= FULL) theta -= FULL;
    while (theta < 0.0) theta += FULL;
    sin_in  = quant(AMPL * $sin(theta * TWO_PI / FULL));
    cos_in  = quant(AMPL * $cos(theta * TWO_PI / FULL));
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (SPS - 2) @(negedge clk);
  endtask

  task automatic lock_static(input real target);
    int run = 0;
    bit done = 0;
    real lag = 0.0;
    theta = target;
    vrate = 0.0;
    for (int k = 0; k < 3000 && !done; k++) begin
      one_sample();
      lag = absr(wrapd(real'(angle) - theta));
      run = (lag <= 2.0) ? run + 1 : 0;
      if (run >= 50) done = 1;
    end
    check(done, "R2 R3 R10", $sformatf("static lock at %0.1f, lag", target), lag, 2.0);
  endtask

  task automatic track(input real v);
    real max_lag = 0.0, sum_v = 0.0, exp_v, tol;
    vrate = v;
    repeat (2500) one_sample();
    for (int k = 0; k < 400; k++) begin
      one_sample();
      if (absr(wrapd(real'(angle) - theta)) > max_lag) max_lag = absr(wrapd(real'(angle) - theta));
      sum_v += real'(vel);
    end
    check(max_lag <= 6.0, "R7", $sformatf("rotation %0.2f max lag", v), max_lag, 6.0);
    exp_v = v * real'(1 << ACC_W) / real'(SPS);
    tol = absr(exp_v) * 0.08;
    if (tol < 400.0) tol = 400.0;
    check(absr(sum_v / 400.0 - exp_v) <= tol, "R8", $sformatf("rotation %0.2f mean velocity", v),
          sum_v / 400.0, exp_v);
  endtask

  initial begin
    int vmax_seen = -VMAX - 1, vmin_seen = VMAX + 1;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(angle == '0, "R1", "reset angle", real'(angle), 0.0);
    check(vel == '0, "R1", "reset velocity", real'(vel), 0.0);
    check(!up, "R1", "reset up pulse", real'(up), 0.0);
    check(!dn, "R1", "reset down pulse", real'(dn), 0.0);

    lock_static(300.0);
    lock_static(2050.0);
    lock_static(4000.0);
    lock_static(1024.0);
    lock_static(2900.0);

    track(1.0);
    track(-2.5);
    for (int n = 0; n < 3; n++)
      track(real'(int'($urandom_range(0, 600)) - 300) / 100.0);

    vrate = 6.0;
    for (int k = 0; k < 600; k++) begin
      one_sample();
      if (int'(vel) > vmax_seen) vmax_seen = int'(vel);
      if (int'(vel) < vmin_seen) vmin_seen = int'(vel);
    end
    check(vmax_seen == VMAX, "R9", "overspeed peak velocity", real'(vmax_seen), real'(VMAX));
    check(vmin_seen >= -VMAX, "R9", "overspeed velocity floor", real'(vmin_seen), real'(-VMAX));

    check(excl_err == 0, "R5", "cycles with both pulses", real'(excl_err), 0.0);
    check(step_err == 0, "R4", "angle steps not matching pulses", real'(step_err), 0.0);
    check(wrap_up > 0, "R6", "wraps from all ones to zero", real'(wrap_up), 1.0);
    check(wrap_dn > 0, "R6", "wraps from zero to all ones", real'(wrap_dn), 1.0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule